// File: doc/BRIEF.md
# Serial SAR Converter Frame Reader

This block is the master side of a three-wire link to a successive-approximation converter. It drives the converter's active-low select line and its serial clock. It shifts in one 16-bit frame per conversion and hands the result to the rest of the chip as a parallel word with a one-cycle strobe. All of its timing is derived from the system clock. The serial clock half-period, the select-to-first-edge setup and the idle gap between frames are parameters counted in system cycles. Elaboration is refused when these parameters, at the given system clock period, would break the converter's minimum timing.

A frame holds four leading zero bits, then the conversion result with its most significant bit first. In the 10-bit variant two padding bits end the frame. The resolution is a parameter. When a leading bit reads as one, the block raises a framing flag alongside that frame's result, and the data word is still delivered. In single-shot operation a start pulse launches one frame. In continuous operation frames repeat back to back, separated only by the idle gap.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held and right after it, `adc_cs_n` and `adc_sclk` are 1, `result_valid` and `framing_error` are 0, and `result_data` is 0.
- R2: Each frame has exactly 16 falling edges of `adc_sclk` while `adc_cs_n` is 0. `adc_sclk` is 1 whenever `adc_cs_n` changes level.
- R3: Inside a frame every low and every high half of `adc_sclk` lasts exactly SCLK_HALF system cycles. Elaboration fails unless SCLK_HALF*SYS_CLK_NS is at least 40 ns and the full period is no faster than 18 MHz.
- R4: From the falling edge of `adc_cs_n` to the first falling edge of `adc_sclk` there are exactly SETUP_CYC system cycles, and elaboration requires at least 10 ns.
- R5: Frame bit k (k = 1..16) is the value `adc_sdata` holds after the k-th falling edge of `adc_sclk`. It is sampled on the system clock edge at which `adc_sclk` returns high, and bit 1 is the first bit shifted in.
- R6: With RES_BITS = 12, frame bits 5..16 become `result_data[11:0]`, bit 5 landing in bit 11.
- R7: With RES_BITS = 10, frame bits 5..14 become `result_data[9:0]`, bit 5 landing in bit 9. `result_data[11:10]` is 0, and frame bits 15 and 16 have no effect on any output.
- R8: `framing_error` is 1 together with a result exactly when any of frame bits 1..4 was 1. The data word is delivered either way, and both outputs hold until the next result.
- R9: `result_valid` is a single-cycle pulse. It is asserted in the cycle in which `adc_cs_n` returns to 1, and only then.
- R10: Between two frames `adc_cs_n` stays 1 for at least QUIET_CYC cycles, and elaboration requires at least 60 ns. In continuous mode the gap is exactly QUIET_CYC cycles.
- R11: With `continuous` at 0, a frame begins only when `start` is 1 while the block is idle. A `start` that arrives during a frame or during the idle gap after it launches no frame.
- R12: When `continuous` is 0 and no start is given, no frame begins. Dropping `continuous` lets the current frame finish and then leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| continuous | input | 1 | 1: frames repeat automatically; 0: single-shot on `start` |
| start | input | 1 | Single-shot launch request, taken only when idle |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low converter select; its falling edge starts a conversion |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| result_data | output | 12 | Last conversion result, zero-extended in 10-bit mode |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| framing_error | output | 1 | Leading-zero check failed for the current result |

## Verification
The bench builds two copies side by side at a 125 MHz system clock, one at 12-bit and one at 10-bit resolution. Both use SCLK_HALF = 5, SETUP_CYC = 2 and QUIET_CYC = 8, which are the smallest values the elaboration checks accept at that period. Every serial half-period, setup and gap is therefore measured at its legal limit. Short frames allow several hundred conversions within the run. These cover a stride sweep over the result codes, the all-zero and all-one codes, a walking one through each leading-bit position, and nonzero padding bits. Start pulses placed in the middle of a frame and inside the idle gap exercise the single-shot rule, and dropping the continuous mode mid-stream shows the block coming to rest.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  // Frame shape seen on the serial line
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int WORD_W     = FRAME_BITS - LEAD_BITS;
  localparam int BIT_CNT_W  = $clog2(FRAME_BITS + 1);

  // Converter timing limits (ns, MHz)
  localparam int SCLK_MAX_MHZ    = 18;
  localparam int DATA_VALID_NS   = 40;
  localparam int CS_SETUP_MIN_NS = 10;
  localparam int CS_HIGH_MIN_NS  = 10;
  localparam int QUIET_MIN_NS    = 60;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_QUIET = 3'd4
  } seq_state_e;

endpackage

// File: rtl/adcr_rst_sync.sv
module adcr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end

endmodule

// File: rtl/adcr_sequencer.sv
module adcr_sequencer
  import adcr_pkg::*;
#(
  parameter int SCLK_HALF = 5,
  parameter int SETUP_CYC = 2,
  parameter int QUIET_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic continuous,
  input  logic start,
  output logic cs_n_o,
  output logic sclk_o,
  output logic sample_tick,
  output logic frame_done
);

  localparam int MAX_A   = (SCLK_HALF > SETUP_CYC) ? SCLK_HALF : SETUP_CYC;
  localparam int MAX_CNT = (MAX_A > QUIET_CYC) ? MAX_A : QUIET_CYC;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(SCLK_HALF - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] QUIET_LD = CNT_W'(QUIET_CYC - 1);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS);

  seq_state_e             state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [BIT_CNT_W-1:0]   bit_q, bit_d;
  logic                   cnt_done;
  logic                   last_bit;

  assign cnt_done = (cnt_q == '0);
  assign last_bit = (bit_q == LAST_BIT);

  // Next-state: one shared down-counter times every phase
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    bit_d       = bit_q;
    sample_tick = 1'b0;
    frame_done  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (continuous || start) begin
          state_d = ST_SETUP;
          cnt_d   = SETUP_LD;
          bit_d   = '0;
        end
      end
      ST_SETUP: begin
        if (cnt_done) begin
          state_d = ST_LOW;
          cnt_d   = HALF_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_LOW: begin
        if (cnt_done) begin
          state_d     = ST_HIGH;
          cnt_d       = HALF_LD;
          bit_d       = bit_q + 1'b1;
          sample_tick = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HIGH: begin
        if (cnt_done) begin
          if (last_bit) begin
            state_d    = ST_QUIET;
            cnt_d      = QUIET_LD;
            frame_done = 1'b1;
          end else begin
            state_d = ST_LOW;
            cnt_d   = HALF_LD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_QUIET: begin
        if (cnt_done) begin
          if (continuous) begin
            state_d = ST_SETUP;
            cnt_d   = SETUP_LD;
            bit_d   = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        bit_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
    end
  end

  assign cs_n_o = (state_q == ST_IDLE) || (state_q == ST_QUIET);
  assign sclk_o = (state_q != ST_LOW);

  // Level run-length counters observed by the timing assertions
  logic [CNT_W:0] lo_run, hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= '0;
    end else begin
      lo_run <= (!sclk_o) ? lo_run + 1'b1 : '0;
      hi_run <= (!cs_n_o && sclk_o) ? hi_run + 1'b1 : '0;
    end
  end

  AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> lo_run == (CNT_W+1)'(SCLK_HALF));  // R3
  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && bit_q != '0) |-> hi_run == (CNT_W+1)'(SCLK_HALF));  // R3
  AST_SETUP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk_o) && bit_q == '0) |-> hi_run == (CNT_W+1)'(SETUP_CYC));  // R4
  AST_FALL_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> !cs_n_o);  // R2
  AST_BITS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> bit_q == LAST_BIT);  // R2

endmodule

// File: rtl/adcr_deframer.sv
module adcr_deframer
  import adcr_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              sample_tick,
  input  logic              frame_done,
  output logic [WORD_W-1:0] result_data,
  output logic              result_valid,
  output logic              framing_error
);

  localparam int PAD_W = WORD_W - RES_BITS;

  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic [WORD_W-1:0]     payload;
  logic [WORD_W-1:0]     res_ext;
  logic                  lead_bad;
  logic [WORD_W-1:0]     data_d;
  logic                  ferr_d;

  assign shift_d  = {shift_q[FRAME_BITS-2:0], sdata};
  assign payload  = shift_q[WORD_W-1:0];
  assign lead_bad = |shift_q[FRAME_BITS-1 -: LEAD_BITS];

  // Resolution variant: full-width word, or right-justify and drop pad bits
  if (PAD_W == 0) begin : g_full
    assign res_ext = payload;
  end else begin : g_padded
    assign res_ext = {{PAD_W{1'b0}}, payload[WORD_W-1:PAD_W]};
  end

  always_comb begin
    data_d = result_data;
    ferr_d = framing_error;
    if (frame_done) begin
      data_d = res_ext;
      ferr_d = lead_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (sample_tick) begin
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_data   <= '0;
      framing_error <= 1'b0;
      result_valid  <= 1'b0;
    end else begin
      result_data   <= data_d;
      framing_error <= ferr_d;
      result_valid  <= frame_done;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);  // R9
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(result_data) && $stable(framing_error)));  // R8
  AST_FERR_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framing_error) |-> result_valid);  // R8

  if (PAD_W > 0) begin : g_pad_chk
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      result_data[WORD_W-1:RES_BITS] == '0);  // R7
  end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adcr_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int SYS_CLK_NS = 8,
  parameter int SCLK_HALF  = 5,
  parameter int SETUP_CYC  = 2,
  parameter int QUIET_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              continuous,
  input  logic              start,
  input  logic              adc_sdata,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic [WORD_W-1:0] result_data,
  output logic              result_valid,
  output logic              framing_error
);

  localparam int HALF_NS   = SCLK_HALF * SYS_CLK_NS;
  localparam int PERIOD_NS = 2 * HALF_NS;
  localparam int SETUP_NS  = SETUP_CYC * SYS_CLK_NS;
  localparam int QUIET_NS  = QUIET_CYC * SYS_CLK_NS;

  // Elaboration guards on the converter's timing limits (R3, R4, R10)
  if (RES_BITS != 12 && RES_BITS != 10) begin : g_bad_res
    $error("adc_frame_reader: RES_BITS must be 10 or 12");
  end
  if (PERIOD_NS * SCLK_MAX_MHZ < 1000) begin : g_bad_rate
    $error("adc_frame_reader: serial clock faster than allowed");
  end
  if (SCLK_HALF < 1 || HALF_NS < DATA_VALID_NS) begin : g_bad_half
    $error("adc_frame_reader: serial half-period shorter than data-valid delay");
  end
  if (SETUP_CYC < 1 || SETUP_NS < CS_SETUP_MIN_NS) begin : g_bad_setup
    $error("adc_frame_reader: select setup too short");
  end
  if (QUIET_CYC < 1 || QUIET_NS < QUIET_MIN_NS || QUIET_NS < CS_HIGH_MIN_NS) begin : g_bad_quiet
    $error("adc_frame_reader: idle gap too short");
  end

  logic rst_n_int;
  logic sample_tick;
  logic frame_done;

  adcr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  adcr_sequencer #(
    .SCLK_HALF (SCLK_HALF),
    .SETUP_CYC (SETUP_CYC),
    .QUIET_CYC (QUIET_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .continuous  (continuous),
    .start       (start),
    .cs_n_o      (adc_cs_n),
    .sclk_o      (adc_sclk),
    .sample_tick (sample_tick),
    .frame_done  (frame_done)
  );

  adcr_deframer #(
    .RES_BITS (RES_BITS)
  ) u_deframe (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .sdata         (adc_sdata),
    .sample_tick   (sample_tick),
    .frame_done    (frame_done),
    .result_data   (result_data),
    .result_valid  (result_valid),
    .framing_error (framing_error)
  );

  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n_int)
    result_valid |-> (adc_cs_n && $past(!adc_cs_n)));  // R9

endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;

  localparam int SYS_NS = 8;
  localparam int HALF   = 5;
  localparam int SETUP  = 2;
  localparam int QUIET  = 8;
  localparam int FRAME_CYC = SETUP + 32 * HALF + QUIET;
  localparam int SWEEP  = 560;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, continuous, start;
  int   n_chk = 0;
  int   n_err = 0;
  bit   ended = 1'b0;

  logic        cs_n_a  [2];
  logic        sclk_a  [2];
  logic        valid_a [2];
  logic        ferr_a  [2];
  logic [11:0] data_a  [2];
  int          frames_a[2];

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!ended) begin
      ended = 1'b1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  // Stimulus content per frame index
  function automatic logic [11:0] pay_val(int idx);
    if (idx % 97 == 0) return 12'h000;
    if (idx % 97 == 1) return 12'hFFF;
    return 12'((idx * 1237 + 5) % 4096);
  endfunction

  function automatic logic [3:0] lead_val(int idx);
    if (idx % 5 == 4) return 4'(1 << ((idx / 5) % 4));
    return 4'h0;
  endfunction

  function automatic logic [15:0] frame_word(int idx, int rb);
    logic [11:0] pv;
    pv = pay_val(idx);
    if (rb == 12) return {lead_val(idx), pv};
    return {lead_val(idx), pv[9:0], 2'(1 + idx % 3)};
  endfunction

  function automatic logic [11:0] exp_data(int idx, int rb);
    logic [11:0] pv;
    pv = pay_val(idx);
    if (rb == 12) return pv;
    return {2'b00, pv[9:0]};
  endfunction

  for (genvar g = 0; g < 2; g++) begin : g_dut
    localparam int RB = (g == 0) ? 12 : 10;
    logic sdata = 1'b1;
    int   fidx = -1;
    int   bpos = 0;
    logic [15:0] word = '0;

    adc_frame_reader #(
      .RES_BITS   (RB),
      .SYS_CLK_NS (SYS_NS),
      .SCLK_HALF  (HALF),
      .SETUP_CYC  (SETUP),
      .QUIET_CYC  (QUIET)
    ) u_adc_frame_reader (
      .clk           (clk),
      .rst_n         (rst_n),
      .continuous    (continuous),
      .start         (start),
      .adc_sdata     (sdata),
      .adc_cs_n      (cs_n_a[g]),
      .adc_sclk      (sclk_a[g]),
      .result_data   (data_a[g]),
      .result_valid  (valid_a[g]),
      .framing_error (ferr_a[g])
    );

    assign frames_a[g] = fidx + 1;

    // Converter model: bit k appears after the k-th falling edge (R5)
    always @(negedge cs_n_a[g]) begin
      fidx = fidx + 1;
      word = frame_word(fidx, RB);
      bpos = 0;
    end

    always @(negedge sclk_a[g]) begin
      if (cs_n_a[g] == 1'b0 && bpos < 16) begin
        sdata <= word[15 - bpos];
        bpos = bpos + 1;
      end
    end

    // Timing and result monitor, sampled mid-cycle
    logic pcs = 1'b1, psclk = 1'b1, pvalid = 1'b0;
    int   run = 0, run_hi = 0, nfall = 0;
    bit   seen = 1'b0, end_cont = 1'b0;

    always @(negedge clk) begin
      if (rst_n) begin
        if (!cs_n_a[g] && sclk_a[g] != psclk) begin
          if (psclk && nfall == 0)
            check(run == SETUP, "R4", "select-to-first-fall cycles", run, SETUP);
          else
            check(run == HALF, "R3", "serial half-period cycles", run, HALF);
          if (!sclk_a[g]) nfall = nfall + 1;
          run = 1;
        end else begin
          run = run + 1;
        end
        if (pcs && !cs_n_a[g]) begin
          check(sclk_a[g] == 1'b1, "R2", "sclk level at select fall", sclk_a[g], 1);
          if (seen)
            check(run_hi >= QUIET, "R10", "idle gap cycles", run_hi, QUIET);
          if (seen && end_cont && continuous)
            check(run_hi == QUIET, "R10", "continuous gap cycles", run_hi, QUIET);
          nfall = 0;
          run = 1;
        end
        if (!pcs && cs_n_a[g]) begin
          check(nfall == 16, "R2", "falling edges per frame", nfall, 16);
          check(sclk_a[g] == 1'b1, "R2", "sclk level at select rise", sclk_a[g], 1);
          check(valid_a[g] == 1'b1, "R9", "strobe at select rise", valid_a[g], 1);
          seen = 1'b1;
          end_cont = continuous;
        end
        if (valid_a[g]) begin
          check(pcs == 1'b0 && cs_n_a[g] == 1'b1, "R9", "strobe outside select rise",
                cs_n_a[g], 1);
          check(!pvalid, "R9", "strobe longer than one cycle", pvalid, 0);
          // R5 ordering with R6 (12-bit) or R7 (10-bit, pads ignored)
          check(data_a[g] == exp_data(fidx, RB), (RB == 12) ? "R6" : "R7",
                "result word", data_a[g], exp_data(fidx, RB));
          check(ferr_a[g] == (lead_val(fidx) != 4'h0), "R8", "framing flag",
                ferr_a[g], (lead_val(fidx) != 4'h0));
        end
        if (cs_n_a[g]) run_hi = run_hi + 1;
        else run_hi = 0;
        pcs = cs_n_a[g];
        psclk = sclk_a[g];
        pvalid = valid_a[g];
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog: actual=%0d expected=%0d", 190000, 0);
    report();
  end

  initial begin
    int f0;
    rst_n = 1'b0;
    continuous = 1'b0;
    start = 1'b0;
    repeat (5) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(cs_n_a[k] == 1'b1, "R1", "cs_n in reset", cs_n_a[k], 1);
      check(sclk_a[k] == 1'b1, "R1", "sclk in reset", sclk_a[k], 1);
      check(valid_a[k] == 1'b0, "R1", "valid in reset", valid_a[k], 0);
      check(ferr_a[k] == 1'b0, "R1", "framing flag in reset", ferr_a[k], 0);
      check(data_a[k] == 12'h0, "R1", "data in reset", data_a[k], 0);
    end
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(frames_a[k] == 0, "R12", "frames without start", frames_a[k], 0);
      check(cs_n_a[k] == 1'b1 && data_a[k] == 12'h0, "R1", "idle after reset",
            data_a[k], 0);
    end

    // Single shot, then a start mid-frame and one inside the idle gap (R11)
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!valid_a[0]) @(negedge clk);
    repeat (2) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (400) @(negedge clk);
    for (int k = 0; k < 2; k++)
      check(frames_a[k] == 1, "R11", "frames after busy starts", frames_a[k], 1);

    for (int i = 0; i < 9; i++) begin
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (FRAME_CYC + 30) @(negedge clk);
    end
    for (int k = 0; k < 2; k++)
      check(frames_a[k] == 10, "R11", "single-shot frame count", frames_a[k], 10);

    // Continuous sweep over codes and leading-bit faults (R10)
    continuous = 1'b1;
    repeat (SWEEP * FRAME_CYC) @(negedge clk);
    continuous = 1'b0;
    repeat (400) @(negedge clk);
    for (int k = 0; k < 2; k++)
      check(frames_a[k] - 10 >= SWEEP - 5, "R10", "continuous frame count",
            frames_a[k] - 10, SWEEP);
    f0 = frames_a[0];
    repeat (600) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      check(frames_a[k] == f0, "R12", "frames after dropping continuous",
            frames_a[k], f0);
      check(cs_n_a[k] == 1'b1, "R12", "select idle after stop", cs_n_a[k], 1);
    end
    report();
  end

endmodule